// File: doc/BRIEF.md
# Channel Error and Timeout Monitor

This block watches one transfer channel and records why that channel needs attention. It decodes eight cause events from the channel's handshakes. A transfer can finish, a read or write response can carry an error, the channel FIFO can be pushed while full or popped while empty, a read or a write can stay outstanding too long, and an active channel can go too long without starting a burst. Each event sets a sticky flag in an eight-bit cause vector.

Software clears flags by writing ones to the clear port. An enable mask selects which flags drive the single registered interrupt line. The FIFO, the bus master and any register access path sit outside this block; it only samples their strobes and status levels.

The three stall checks share one timer module. For the bus directions the timer tracks an outstanding request. For the watchdog it runs off the channel's activity level.

Top module: `chan_err_monitor`

## Requirements
- R1: Cause bit 0 sets when `xfer_done_i` is high. Bit 1 sets when `rd_resp_i` and `rd_err_i` are both high. Bit 2 sets when `wr_resp_i` and `wr_err_i` are both high. A response without error sets nothing.
- R2: Cause bit 3 sets on a FIFO push while `fifo_full_i` is high. Cause bit 4 sets on a pop while `fifo_empty_i` is high. A push or pop when the FIFO is not full or not empty sets nothing.
- R3: Cause bit 5 sets on the clock edge that comes RD_LIMIT (default 1024) cycles after the edge that sampled `rd_req_i`, if no `rd_resp_i` was seen in between. A new `rd_req_i` restarts the count.
- R4: Cause bit 6 behaves like bit 5 for writes, using `wr_req_i`, `wr_resp_i` and WR_LIMIT (default 1024).
- R5: A response sampled on or before the edge where the timeout would fire ends the outstanding access. No timeout flag is raised for that access.
- R6: Cause bit 7 sets after WDOG_LIMIT (default 2048) consecutive edges with `chan_active_i` high and `burst_start_i` low. A burst start, or a cycle with the channel inactive, restarts the count.
- R7: A set flag stays set until a one is written to the matching bit of `clr_i`. Zero bits of `clr_i`, and ones on flags that are already clear, change nothing.
- R8: When a flag's event and its clear bit arrive in the same cycle, the flag ends up set.
- R9: `irq_o` is a register that, after each edge, equals the OR over all bits of the newly registered causes ANDed with `irq_en_i`. A masked flag does not raise it.
- R10: After reset all cause flags and `irq_o` are zero.
- R11: A timeout or watchdog expiry fires only once per request or idle stretch. After it is cleared, it does not set again until a new request, burst start or inactive cycle restarts the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chan_active_i | input | 1 | Channel is enabled and has work |
| burst_start_i | input | 1 | Channel starts a bus burst this cycle |
| xfer_done_i | input | 1 | Transfer complete strobe |
| rd_req_i | input | 1 | Bus read request issued |
| rd_resp_i | input | 1 | Bus read response received |
| rd_err_i | input | 1 | Read response carries an error |
| wr_req_i | input | 1 | Bus write request issued |
| wr_resp_i | input | 1 | Bus write response received |
| wr_err_i | input | 1 | Write response carries an error |
| fifo_push_i | input | 1 | FIFO push strobe |
| fifo_pop_i | input | 1 | FIFO pop strobe |
| fifo_full_i | input | 1 | FIFO is full |
| fifo_empty_i | input | 1 | FIFO is empty |
| irq_en_i | input | 8 | Per-cause interrupt enable |
| clr_i | input | 8 | Write-one-to-clear strobes for causes |
| cause_o | output | 8 | Sticky cause flags |
| irq_o | output | 1 | Registered interrupt |

## Verification
The bench samples the stall timers one cycle before and exactly at their limits. A counter that is off by one would either flag an access that got its response in time or miss the boundary. It restarts a read halfway through its window to catch a timer that ignores a second request and fires too early. It also holds an expired request after clearing, to catch a timer that fires repeatedly.

For the watchdog, the bench checks restarts from both a burst start and a one-cycle drop in activity. For the flags, it checks that a set and a clear arriving together leave the flag set, and that a clear only removes its own bit. It also flips the enable mask to show that the interrupt follows the mask.

// File: rtl/chan_err_monitor_pkg.sv
package chan_err_monitor_pkg;

    localparam int unsigned NUM_CAUSES = 8;

    // Cause bit positions; software decodes these, so the order is fixed.
    localparam int unsigned CB_DONE    = 0;
    localparam int unsigned CB_RD_ERR  = 1;
    localparam int unsigned CB_WR_ERR  = 2;
    localparam int unsigned CB_OVFL    = 3;
    localparam int unsigned CB_UNFL    = 4;
    localparam int unsigned CB_RD_TMO  = 5;
    localparam int unsigned CB_WR_TMO  = 6;
    localparam int unsigned CB_WDOG    = 7;

    typedef logic [NUM_CAUSES-1:0] cause_vec_t;

endpackage

// File: rtl/chan_err_event_decode.sv
module chan_err_event_decode
    import chan_err_monitor_pkg::*;
(
    input  logic       xfer_done_i,
    input  logic       rd_resp_i,
    input  logic       rd_err_i,
    input  logic       wr_resp_i,
    input  logic       wr_err_i,
    input  logic       fifo_push_i,
    input  logic       fifo_pop_i,
    input  logic       fifo_full_i,
    input  logic       fifo_empty_i,
    input  logic       rd_tmo_i,
    input  logic       wr_tmo_i,
    input  logic       wdog_i,
    output cause_vec_t set_o
);

    always_comb begin
        set_o            = '0;
        set_o[CB_DONE]   = xfer_done_i;                  // R1
        set_o[CB_RD_ERR] = rd_resp_i && rd_err_i;        // R1
        set_o[CB_WR_ERR] = wr_resp_i && wr_err_i;        // R1
        set_o[CB_OVFL]   = fifo_push_i && fifo_full_i;   // R2
        set_o[CB_UNFL]   = fifo_pop_i && fifo_empty_i;   // R2
        set_o[CB_RD_TMO] = rd_tmo_i;                     // R3
        set_o[CB_WR_TMO] = wr_tmo_i;                     // R4
        set_o[CB_WDOG]   = wdog_i;                       // R6
    end

endmodule

// File: rtl/chan_err_stall_timer.sv
// Counts cycles of a stalled condition and pulses expire_o once at LIMIT.
// LATCHED=1: start_i opens an outstanding access, end_i closes it.
// LATCHED=0: the timer runs while end_i is low; start_i or end_i restart it.
module chan_err_stall_timer #(
    parameter int unsigned LIMIT   = 1024,
    parameter bit          LATCHED = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic end_i,
    output logic expire_o
);

    localparam int unsigned CW = (LIMIT > 2) ? $clog2(LIMIT) : 1;
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    typedef struct packed {
        logic          busy;
        logic          fired;
        logic [CW-1:0] cnt;
    } tmr_state_t;

    tmr_state_t st_d, st_q;
    logic       run_w, clear_w, busy_nxt_w;

    generate
        if (LATCHED) begin : g_track
            assign clear_w    = start_i;
            assign run_w      = st_q.busy && !end_i;
            assign busy_nxt_w = start_i ? 1'b1 : (end_i ? 1'b0 : st_q.busy);
        end else begin : g_level
            assign clear_w    = start_i || end_i;
            assign run_w      = !end_i;
            assign busy_nxt_w = st_q.busy;
        end
    endgenerate

    always_comb begin
        st_d      = st_q;
        expire_o  = 1'b0;
        st_d.busy = busy_nxt_w;
        if (clear_w) begin
            st_d.cnt   = '0;
            st_d.fired = 1'b0;
        end else if (run_w && !st_q.fired) begin
            if (st_q.cnt == LAST) begin
                expire_o   = 1'b1;
                st_d.fired = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_SINGLE_EXPIRE: assert property (@(posedge clk) disable iff (!rst_n)
        expire_o |=> !expire_o);                                    // R11
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= LAST);                                          // R3
    AST_RESTART_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> !expire_o);                                     // R5

endmodule

// File: rtl/chan_err_cause_reg.sv
module chan_err_cause_reg
    import chan_err_monitor_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  cause_vec_t set_i,
    input  cause_vec_t clr_i,
    input  cause_vec_t en_i,
    output cause_vec_t cause_o,
    output logic       irq_o
);

    typedef struct packed {
        cause_vec_t cause;
        logic       irq;
    } cr_state_t;

    cr_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.cause = (st_q.cause & ~clr_i) | set_i;   // set beats clear
        st_d.irq   = |(st_d.cause & en_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cause_o = st_q.cause;
    assign irq_o   = st_q.irq;

    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((cause_o & $past(cause_o & ~clr_i)) == $past(cause_o & ~clr_i))); // R7
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_i) |=> ((cause_o & $past(set_i)) == $past(set_i)));   // R8
    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (|(clr_i & ~set_i)) |=> ((cause_o & $past(clr_i & ~set_i)) == '0)); // R7
    AST_IRQ_NEEDS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (|cause_o));                                      // R9

endmodule

// File: rtl/chan_err_monitor.sv
module chan_err_monitor
    import chan_err_monitor_pkg::*;
#(
    parameter int unsigned RD_LIMIT   = 1024,
    parameter int unsigned WR_LIMIT   = 1024,
    parameter int unsigned WDOG_LIMIT = 2048
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       chan_active_i,
    input  logic       burst_start_i,
    input  logic       xfer_done_i,
    input  logic       rd_req_i,
    input  logic       rd_resp_i,
    input  logic       rd_err_i,
    input  logic       wr_req_i,
    input  logic       wr_resp_i,
    input  logic       wr_err_i,
    input  logic       fifo_push_i,
    input  logic       fifo_pop_i,
    input  logic       fifo_full_i,
    input  logic       fifo_empty_i,
    input  logic [7:0] irq_en_i,
    input  logic [7:0] clr_i,
    output logic [7:0] cause_o,
    output logic       irq_o
);

    logic       rd_tmo_w, wr_tmo_w, wdog_w;
    cause_vec_t set_w;

    chan_err_stall_timer #(.LIMIT(RD_LIMIT), .LATCHED(1'b1)) i_rd_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (rd_req_i),
        .end_i    (rd_resp_i),
        .expire_o (rd_tmo_w)
    );

    chan_err_stall_timer #(.LIMIT(WR_LIMIT), .LATCHED(1'b1)) i_wr_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (wr_req_i),
        .end_i    (wr_resp_i),
        .expire_o (wr_tmo_w)
    );

    chan_err_stall_timer #(.LIMIT(WDOG_LIMIT), .LATCHED(1'b0)) i_wdog_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (burst_start_i),
        .end_i    (!chan_active_i),
        .expire_o (wdog_w)
    );

    chan_err_event_decode i_decode (
        .xfer_done_i  (xfer_done_i),
        .rd_resp_i    (rd_resp_i),
        .rd_err_i     (rd_err_i),
        .wr_resp_i    (wr_resp_i),
        .wr_err_i     (wr_err_i),
        .fifo_push_i  (fifo_push_i),
        .fifo_pop_i   (fifo_pop_i),
        .fifo_full_i  (fifo_full_i),
        .fifo_empty_i (fifo_empty_i),
        .rd_tmo_i     (rd_tmo_w),
        .wr_tmo_i     (wr_tmo_w),
        .wdog_i       (wdog_w),
        .set_o        (set_w)
    );

    chan_err_cause_reg i_cause (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (set_w),
        .clr_i   (clr_i),
        .en_i    (irq_en_i),
        .cause_o (cause_o),
        .irq_o   (irq_o)
    );

    AST_WDOG_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !chan_active_i |=> !cause_o[CB_WDOG] || $past(cause_o[CB_WDOG])); // R6
    AST_RESET_CLEAN: assert property (@(posedge clk)
        !rst_n |-> (cause_o == '0 && !irq_o));                        // R10

endmodule

// File: tb/test_chan_err_monitor.sv
module test_chan_err_monitor;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       chan_active_i = 1'b0, burst_start_i = 1'b0, xfer_done_i = 1'b0;
    logic       rd_req_i = 1'b0, rd_resp_i = 1'b0, rd_err_i = 1'b0;
    logic       wr_req_i = 1'b0, wr_resp_i = 1'b0, wr_err_i = 1'b0;
    logic       fifo_push_i = 1'b0, fifo_pop_i = 1'b0;
    logic       fifo_full_i = 1'b0, fifo_empty_i = 1'b0;
    logic [7:0] irq_en_i = 8'hFF, clr_i = 8'h00;
    logic [7:0] cause_o;
    logic       irq_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    chan_err_monitor i_chan_err_monitor (.*);

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %02h expected %02h", tag, got, exp);
        end
    endtask

    task automatic clear_all();
        clr_i = 8'hFF; cyc(1); clr_i = 8'h00;
    endtask

    task automatic t_reset();
        chk("R10 cause in reset", cause_o, 8'h00);
        chk("R10 irq in reset", {7'b0, irq_o}, 8'h00);
        rst_n = 1'b1; cyc(2);
        chk("R10 cause after reset", cause_o, 8'h00);
    endtask

    task automatic t_simple_events();
        rd_resp_i = 1; cyc(1); rd_resp_i = 0;
        chk("R1 read resp no error", cause_o, 8'h00);
        xfer_done_i = 1; cyc(1); xfer_done_i = 0;
        chk("R1 done bit0", cause_o, 8'h01);
        rd_resp_i = 1; rd_err_i = 1; cyc(1); rd_resp_i = 0; rd_err_i = 0;
        chk("R1 read error bit1", cause_o, 8'h03);
        wr_resp_i = 1; wr_err_i = 1; cyc(1); wr_resp_i = 0; wr_err_i = 0;
        chk("R1 write error bit2", cause_o, 8'h07);
        clear_all();
        fifo_push_i = 1; cyc(1);
        chk("R2 push not full", cause_o, 8'h00);
        fifo_full_i = 1; cyc(1); fifo_push_i = 0; fifo_full_i = 0;
        chk("R2 overflow bit3", cause_o, 8'h08);
        fifo_pop_i = 1; cyc(1);
        chk("R2 pop not empty", cause_o, 8'h08);
        fifo_empty_i = 1; cyc(1); fifo_pop_i = 0; fifo_empty_i = 0;
        chk("R2 underflow bit4", cause_o, 8'h18);
    endtask

    task automatic t_clear();
        xfer_done_i = 1; cyc(1); xfer_done_i = 0;
        chk("R7 setup", cause_o, 8'h19);
        clr_i = 8'h01; cyc(1); clr_i = 8'h00;
        chk("R7 clear bit0 only", cause_o, 8'h18);
        clr_i = 8'h80; cyc(1); clr_i = 8'h00;
        chk("R7 clear of clear bit", cause_o, 8'h18);
        cyc(5);
        chk("R7 sticky hold", cause_o, 8'h18);
        xfer_done_i = 1; clr_i = 8'h01; cyc(1); xfer_done_i = 0; clr_i = 8'h00;
        chk("R8 set wins (was clear)", cause_o, 8'h19);
        xfer_done_i = 1; clr_i = 8'h11; cyc(1); xfer_done_i = 0; clr_i = 8'h00;
        chk("R8 set wins (was set)", cause_o, 8'h09);
        clear_all();
    endtask

    task automatic t_irq();
        irq_en_i = 8'h00;
        xfer_done_i = 1; cyc(1); xfer_done_i = 0;
        chk("R9 masked cause", {7'b0, irq_o}, 8'h00);
        irq_en_i = 8'h01; cyc(1);
        chk("R9 enabled cause", {7'b0, irq_o}, 8'h01);
        irq_en_i = 8'hFE; cyc(1);
        chk("R9 other bits enabled", {7'b0, irq_o}, 8'h00);
        irq_en_i = 8'hFF;
        clear_all(); cyc(1);
        chk("R9 irq after clear", {7'b0, irq_o}, 8'h00);
    endtask

    task automatic t_read_timeout();
        rd_req_i = 1; cyc(1); rd_req_i = 0;
        cyc(1023);
        chk("R3 before limit", cause_o, 8'h00);
        cyc(1);
        chk("R3 at limit", cause_o, 8'h20);
        clear_all(); cyc(1100);
        chk("R11 read no refire", cause_o, 8'h00);
        rd_resp_i = 1; cyc(1); rd_resp_i = 0;
        rd_req_i = 1; cyc(1); rd_req_i = 0;
        cyc(600);
        rd_req_i = 1; cyc(1); rd_req_i = 0;
        cyc(1023);
        chk("R3 restart holds off", cause_o, 8'h00);
        cyc(1);
        chk("R3 restart fires", cause_o, 8'h20);
        clear_all();
        rd_resp_i = 1; cyc(1); rd_resp_i = 0;
        rd_req_i = 1; cyc(1); rd_req_i = 0;
        cyc(1023);
        rd_resp_i = 1; cyc(1); rd_resp_i = 0;
        chk("R5 read resp at limit", cause_o, 8'h00);
        cyc(1200);
        chk("R5 read stays quiet", cause_o, 8'h00);
    endtask

    task automatic t_write_timeout();
        wr_req_i = 1; cyc(1); wr_req_i = 0;
        cyc(1023);
        chk("R4 before limit", cause_o, 8'h00);
        cyc(1);
        chk("R4 at limit", cause_o, 8'h40);
        clear_all(); cyc(1100);
        chk("R11 write no refire", cause_o, 8'h00);
        wr_resp_i = 1; cyc(1); wr_resp_i = 0;
        wr_req_i = 1; cyc(1); wr_req_i = 0;
        cyc(500);
        wr_resp_i = 1; cyc(1); wr_resp_i = 0;
        cyc(1500);
        chk("R5 write resp early", cause_o, 8'h00);
    endtask

    task automatic t_watchdog();
        chan_active_i = 1;
        cyc(2047);
        chk("R6 before limit", cause_o, 8'h00);
        cyc(1);
        chk("R6 at limit", cause_o, 8'h80);
        clear_all(); cyc(200);
        chk("R11 watchdog no refire", cause_o, 8'h00);
        burst_start_i = 1; cyc(1); burst_start_i = 0;
        cyc(2047);
        chk("R6 burst restart holds off", cause_o, 8'h00);
        cyc(1);
        chk("R6 burst restart fires", cause_o, 8'h80);
        clear_all();
        chan_active_i = 0; cyc(1); chan_active_i = 1;
        cyc(1500);
        chan_active_i = 0; cyc(1); chan_active_i = 1;
        cyc(2047);
        chk("R6 idle restart holds off", cause_o, 8'h00);
        cyc(1);
        chk("R6 idle restart fires", cause_o, 8'h80);
        chan_active_i = 0;
        clear_all();
    endtask

    initial begin
        cyc(3);
        t_reset();
        t_simple_events();
        t_clear();
        t_irq();
        t_read_timeout();
        t_write_timeout();
        t_watchdog();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule